// File: doc/BRIEF.md
# Global-clock asynchronous flip-flop emulator

This block stands in for one flip-flop that has an edge-triggered clock with a clock enable, an asynchronous set, an asynchronous clear and an asynchronous load with its own data input. Everything runs on a single fast global clock (`gclk`). The emulated clock and every control and data input are plain signals that the block samples once per global-clock cycle. The emulated clock edge and the asynchronous behaviour are rebuilt from two values: the copy sampled in the previous cycle and the value present now.

The state sits in one register on `gclk`. Its input is produced by two chained update stages. The first stage acts only on previous-cycle samples: the emulated clock edge, and any set, clear or load that was active one cycle ago. The second stage acts only on the present inputs: set, clear and load. As a result, a control released in the current cycle still acts once, with its sampled value. This is a one-cycle negative hold window. Several inputs that change together also resolve correctly. The visible output is the register's next-state value, so any asynchronous action shows in the same global-clock cycle.

The first cycle after reset is deterministic. Nothing that depends on a previous sample may act in it, including the clock edge. Only present-value level controls can move the output in that cycle.

Top module: `gclk_async_flop`

## Requirements
- R1: After reset is released, with no level control active, `q` equals the parameter `INIT_VAL` in the first cycle.
- R2: A clock edge of the configured polarity, seen between the previous sample of `emu_clk` and its present value, loads the previous sample of `emu_d` into `q`, but only when the previous sample of `emu_ce` was active. With no active operation, `q` keeps its value.
- R3: `q` is the next-state value. A level control asserted in a cycle shows on `q` in that same global-clock cycle, before the state register captures it.
- R4: A present active clear drives `q` to all zeros, overriding every other operation.
- R5: A present active set, without a present clear, drives `q` to all ones.
- R6: A present active asynchronous load, without a present set or clear, drives `q` to the present `emu_ad`.
- R7: When the asynchronous load was active in the previous cycle and is inactive now, `q` takes the previous-cycle sample of `emu_ad`, provided no present control and no sampled set or clear acts.
- R8: A clear that goes inactive in the same cycle that set becomes active does not mask the set: `q` is all ones in that cycle.
- R9: A set or clear that was active in the previous cycle and is released now still acts in this cycle with its sampled value. A sampled clear ranks above a sampled set, and both rank above a sampled load and the clock edge.
- R10: In the first cycle after reset, neither the clock edge nor any sampled operation acts, whatever `emu_clk` does.
- R11: A level control that is active in the first cycle after reset drives `q` for that cycle and overrides `INIT_VAL`.
- R12: Clock enable and asynchronous load are independent inputs. When both a clock edge with enable and a present load occur, the load value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global clock; the only clock of the block |
| rst_n | input | 1 | Active-low asynchronous reset; state to `INIT_VAL`, samples cleared |
| emu_clk | input | 1 | Emulated flip-flop clock, treated as data |
| emu_ce | input | 1 | Emulated clock enable (polarity `CE_HIGH`) |
| emu_d | input | WIDTH | Clocked data |
| emu_set | input | 1 | Asynchronous set (polarity `SET_HIGH`), all bits to one |
| emu_clr | input | 1 | Asynchronous clear (polarity `CLR_HIGH`), all bits to zero |
| emu_aload | input | 1 | Asynchronous load enable (polarity `LOAD_HIGH`) |
| emu_ad | input | WIDTH | Asynchronous load data |
| q | output | WIDTH | Emulated flip-flop output (next-state value) |

## Verification
A corrupted sample register shows up one global-clock cycle after the faulty value is captured. The output then takes a wrong value during the hold window: a stale `emu_ad` on a falling load, a missing zero after a clear is released, or a phantom or lost clock edge. A corrupted state register shows as soon as no operation is active, because `q` passes the state straight through. A first-cycle flag that is set too early fires an edge or a sampled operation in the very first cycle after reset. The bench drives every ordered pair of control patterns. Each cycle it compares `q` with a priority-ordered model of the flip-flop that includes the hold window, so any of these faults differs from the model within one cycle of occurring.

// File: rtl/gaf_pkg.sv
package gaf_pkg;

  // raw emulated control inputs, as seen on the ports
  typedef struct packed {
    logic clk;
    logic ce;
    logic set;
    logic clr;
    logic aload;
  } gaf_ctl_t;

  // a level control is on when it matches its active polarity
  function automatic logic level_on(input logic sig, input logic act_high);
    return sig == act_high;
  endfunction

  // edge between the previous sample and the present value
  function automatic logic edge_seen(input logic prev, input logic cur,
                                     input logic rising);
    return rising ? (!prev && cur) : (prev && !cur);
  endfunction

endpackage

// File: rtl/gaf_sampler.sv
module gaf_sampler
  import gaf_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             gclk,
  input  logic             rst_n,
  input  gaf_ctl_t         now_ctl,
  input  logic [WIDTH-1:0] now_d,
  input  logic [WIDTH-1:0] now_ad,
  output gaf_ctl_t         smp_ctl,
  output logic [WIDTH-1:0] smp_d,
  output logic [WIDTH-1:0] smp_ad,
  output logic             smp_valid
);

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) begin
      smp_ctl   <= '0;
      smp_d     <= '0;
      smp_ad    <= '0;
      smp_valid <= 1'b0;
    end else begin
      smp_ctl   <= now_ctl;
      smp_d     <= now_d;
      smp_ad    <= now_ad;
      smp_valid <= 1'b1;
    end
  end

  // R10: the sample-valid flag is low for exactly one cycle after reset
  p_first_once_r10: assert property (@(posedge gclk) disable iff (!rst_n)
    !smp_valid |=> smp_valid);
  p_valid_sticky_r10: assert property (@(posedge gclk) disable iff (!rst_n)
    smp_valid |=> smp_valid);

endmodule

// File: rtl/gaf_stage.sv
module gaf_stage #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] val_in,
  input  logic             en_clk,
  input  logic [WIDTH-1:0] clk_d,
  input  logic             en_load,
  input  logic [WIDTH-1:0] load_d,
  input  logic             en_set,
  input  logic             en_clr,
  output logic [WIDTH-1:0] val_out
);

  // later assignments win: clear > set > load > clocked update > hold
  always_comb begin
    val_out = val_in;
    if (en_clk)  val_out = clk_d;
    if (en_load) val_out = load_d;
    if (en_set)  val_out = '1;
    if (en_clr)  val_out = '0;
  end

endmodule

// File: rtl/gaf_state.sv
module gaf_state #(
  parameter int               WIDTH    = 4,
  parameter logic [WIDTH-1:0] INIT_VAL = '0
) (
  input  logic             gclk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] next_val,
  output logic [WIDTH-1:0] state_q
);

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) state_q <= INIT_VAL;
    else        state_q <= next_val;
  end

endmodule

// File: rtl/gclk_async_flop.sv
module gclk_async_flop
  import gaf_pkg::*;
#(
  parameter int               WIDTH      = 4,
  parameter logic [WIDTH-1:0] INIT_VAL   = 4'h5,
  parameter bit               CLK_RISING = 1'b1,
  parameter bit               CE_HIGH    = 1'b1,
  parameter bit               SET_HIGH   = 1'b1,
  parameter bit               CLR_HIGH   = 1'b1,
  parameter bit               LOAD_HIGH  = 1'b1
) (
  input  logic             gclk,
  input  logic             rst_n,
  input  logic             emu_clk,
  input  logic             emu_ce,
  input  logic [WIDTH-1:0] emu_d,
  input  logic             emu_set,
  input  logic             emu_clr,
  input  logic             emu_aload,
  input  logic [WIDTH-1:0] emu_ad,
  output logic [WIDTH-1:0] q
);

  localparam int NSTAGE = 2;  // stage 0: sampled values, stage 1: present values

  gaf_ctl_t         now_ctl, smp_ctl;
  logic [WIDTH-1:0] smp_d, smp_ad, state_q;
  logic             smp_valid;

  always_comb begin
    now_ctl.clk   = emu_clk;
    now_ctl.ce    = emu_ce;
    now_ctl.set   = emu_set;
    now_ctl.clr   = emu_clr;
    now_ctl.aload = emu_aload;
  end

  gaf_sampler #(.WIDTH(WIDTH)) u_sampler (
    .gclk      (gclk),
    .rst_n     (rst_n),
    .now_ctl   (now_ctl),
    .now_d     (emu_d),
    .now_ad    (emu_ad),
    .smp_ctl   (smp_ctl),
    .smp_d     (smp_d),
    .smp_ad    (smp_ad),
    .smp_valid (smp_valid)
  );

  // named events, used by the stages and the assertions
  logic clk_edge, smp_clk_upd, smp_load, smp_set, smp_clr;
  logic cur_load, cur_set, cur_clr, cur_any, smp_any;

  assign clk_edge    = smp_valid && edge_seen(smp_ctl.clk, emu_clk, CLK_RISING);
  assign smp_clk_upd = clk_edge && level_on(smp_ctl.ce, CE_HIGH);
  assign smp_load    = smp_valid && level_on(smp_ctl.aload, LOAD_HIGH);
  assign smp_set     = smp_valid && level_on(smp_ctl.set, SET_HIGH);
  assign smp_clr     = smp_valid && level_on(smp_ctl.clr, CLR_HIGH);
  assign cur_load    = level_on(emu_aload, LOAD_HIGH);
  assign cur_set     = level_on(emu_set, SET_HIGH);
  assign cur_clr     = level_on(emu_clr, CLR_HIGH);
  assign cur_any     = cur_load || cur_set || cur_clr;
  assign smp_any     = smp_clk_upd || smp_load || smp_set || smp_clr;

  // per-stage operation enables
  logic [NSTAGE-1:0] st_en_clk, st_en_load, st_en_set, st_en_clr;
  logic [WIDTH-1:0]  st_clk_d  [NSTAGE];
  logic [WIDTH-1:0]  st_load_d [NSTAGE];
  logic [WIDTH-1:0]  chain     [NSTAGE+1];

  assign st_en_clk  = {1'b0,     smp_clk_upd};
  assign st_en_load = {cur_load, smp_load};
  assign st_en_set  = {cur_set,  smp_set};
  assign st_en_clr  = {cur_clr,  smp_clr};
  assign st_clk_d[0]  = smp_d;
  assign st_clk_d[1]  = '0;
  assign st_load_d[0] = smp_ad;
  assign st_load_d[1] = emu_ad;
  assign chain[0]     = state_q;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    gaf_stage #(.WIDTH(WIDTH)) u_stage (
      .val_in  (chain[g]),
      .en_clk  (st_en_clk[g]),
      .clk_d   (st_clk_d[g]),
      .en_load (st_en_load[g]),
      .load_d  (st_load_d[g]),
      .en_set  (st_en_set[g]),
      .en_clr  (st_en_clr[g]),
      .val_out (chain[g+1])
    );
  end

  assign q = chain[NSTAGE];

  gaf_state #(.WIDTH(WIDTH), .INIT_VAL(INIT_VAL)) u_state (
    .gclk     (gclk),
    .rst_n    (rst_n),
    .next_val (q),
    .state_q  (state_q)
  );

  // ---------------- assertions ----------------
  p_clr_first_r4: assert property (@(posedge gclk) disable iff (!rst_n)
    cur_clr |-> q == '0);

  p_set_ones_r5: assert property (@(posedge gclk) disable iff (!rst_n)
    (cur_set && !cur_clr) |-> q == '1);

  p_load_now_r6: assert property (@(posedge gclk) disable iff (!rst_n)
    (cur_load && !cur_set && !cur_clr) |-> q == emu_ad);

  p_load_fall_r7: assert property (@(posedge gclk) disable iff (!rst_n)
    (smp_valid && $past(cur_load) && !cur_any && !smp_set && !smp_clr)
      |-> q == $past(emu_ad));

  p_clr_set_r8: assert property (@(posedge gclk) disable iff (!rst_n)
    (smp_valid && $past(cur_clr) && !cur_clr && cur_set) |-> q == '1);

  p_hold_r2: assert property (@(posedge gclk) disable iff (!rst_n)
    (!cur_any && !smp_any) |-> q == state_q);

  p_edge_r2: assert property (@(posedge gclk) disable iff (!rst_n)
    (smp_clk_upd && !smp_load && !smp_set && !smp_clr && !cur_any)
      |-> q == $past(emu_d));

  p_first_quiet_r10: assert property (@(posedge gclk) disable iff (!rst_n)
    (!smp_valid && !cur_any) |-> q == state_q);

  p_state_next_r3: assert property (@(posedge gclk) disable iff (!rst_n)
    smp_valid |-> state_q == $past(q));

endmodule

// File: tb/test_gclk_async_flop.sv
`timescale 1ns/1ps
module test_gclk_async_flop;

  localparam int         W    = 4;
  localparam logic [3:0] INIT = 4'h5;

  logic         gclk = 1'b0;
  logic         rst_n = 1'b0;
  logic         emu_clk = 0, emu_ce = 0, emu_set = 0, emu_clr = 0, emu_aload = 0;
  logic [W-1:0] emu_d = '0, emu_ad = '0;
  logic [W-1:0] q;

  always #2 gclk = ~gclk;  // 250 MHz

  gclk_async_flop #(.WIDTH(W), .INIT_VAL(INIT)) i_gclk_async_flop (
    .gclk(gclk), .rst_n(rst_n), .emu_clk(emu_clk), .emu_ce(emu_ce),
    .emu_d(emu_d), .emu_set(emu_set), .emu_clr(emu_clr),
    .emu_aload(emu_aload), .emu_ad(emu_ad), .q(q)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model state
  logic [W-1:0] m_state, m_sd, m_sad;
  logic         m_sclk, m_sce, m_sset, m_sclr, m_sload, m_valid;

  task automatic check(input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // control pack: {clk, ce, set, clr, aload}
  task automatic predict(output logic [W-1:0] e, output string tag);
    if (emu_clr) begin
      e = '0; tag = m_valid ? "R4" : "R11";
    end else if (emu_set) begin
      e = '1;
      tag = !m_valid ? "R11" : (m_sclr ? "R8" : "R5");
    end else if (emu_aload) begin
      e = emu_ad;
      tag = !m_valid ? "R11" : ((!m_sclk && emu_clk && m_sce) ? "R12" : "R6");
    end else if (m_valid && m_sclr) begin
      e = '0; tag = "R9";
    end else if (m_valid && m_sset) begin
      e = '1; tag = "R9";
    end else if (m_valid && m_sload) begin
      e = m_sad; tag = "R7";
    end else if (m_valid && !m_sclk && emu_clk && m_sce) begin
      e = m_sd; tag = "R2";
    end else begin
      e = m_state;
      tag = m_valid ? "R2" : (emu_clk ? "R10" : "R1");
    end
  endtask

  // called at a negative edge; returns at the next negative edge
  task automatic step(input logic [4:0] c, input logic [W-1:0] dv,
                      input logic [W-1:0] adv);
    logic [W-1:0] e;
    string        tag;
    {emu_clk, emu_ce, emu_set, emu_clr, emu_aload} = c;
    emu_d  = dv;
    emu_ad = adv;
    #1;
    predict(e, tag);
    check(tag, q, e);  // R3: the value is visible before the gclk edge
    @(posedge gclk);
    m_state = e;
    m_sclk = emu_clk; m_sce = emu_ce; m_sset = emu_set;
    m_sclr = emu_clr; m_sload = emu_aload;
    m_sd = emu_d; m_sad = emu_ad; m_valid = 1'b1;
    @(negedge gclk);
  endtask

  task automatic do_reset();
    @(negedge gclk);
    rst_n = 1'b0;
    {emu_clk, emu_ce, emu_set, emu_clr, emu_aload} = '0;
    repeat (3) @(posedge gclk);
    @(negedge gclk);
    rst_n   = 1'b1;
    m_state = INIT;
    m_valid = 1'b0;
  endtask

  initial begin
    // R1: quiet first cycle shows the initial value
    do_reset();
    step(5'b00000, 4'h3, 4'hC);
    // R10: clock rises in the first cycle with enable: no capture
    do_reset();
    step(5'b11000, 4'hA, 4'h0);
    check("R10", q, INIT);
    // R11: set active in the first cycle overrides the initial value
    do_reset();
    step(5'b00100, 4'h0, 4'h0);
    // R11: load active in the first cycle
    do_reset();
    step(5'b00001, 4'h0, 4'h9);

    // directed: R7 falling load takes the sampled data
    step(5'b00001, 4'h0, 4'h6);
    step(5'b00000, 4'h0, 4'hB);
    check("R7", q, 4'h6);
    // directed: R8 clear falls while set rises
    step(5'b00010, 4'h0, 4'h0);
    step(5'b00100, 4'h0, 4'h0);
    check("R8", q, 4'hF);
    // directed: R9 released clear still clears
    step(5'b00010, 4'h0, 4'h0);
    step(5'b01000, 4'h7, 4'h0);
    step(5'b11000, 4'h2, 4'h0);
    check("R2", q, 4'h7);

    // sweep over every ordered pair of control patterns
    for (int i = 0; i < 1024; i++) begin
      step(5'(i >> 5), 4'(i * 3), 4'(i * 5 + 1));
      step(5'(i),      4'(i * 7 + 2), 4'(i * 11 + 3));
    end

    // sweep again with a fresh reset in between first-cycle patterns
    for (int c = 0; c < 32; c++) begin
      do_reset();
      step(5'(c), 4'(c), 4'(c + 9));
      step(5'(31 - c), 4'(c + 1), 4'(c + 4));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule